// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog counter behind a small four-register write/read port. Firmware keeps it quiet by writing an ordered pair of 16-bit key words to the counter register. Each valid pair restarts the count from zero. If the count climbs to the programmed timeout, the block fires a one-cycle reset request and then freezes until the next system reset. A second, different key pair opens a 128-cycle reconfiguration window. Only inside that window do writes to the control, timeout and window registers take effect. An update-permission bit decides whether such a window may be opened again once a configuration has been applied.

The four registers are selected by a 2-bit word index. Index 0 is control/status at byte offset 0x00. Index 1 is the counter/key register at 0x04. Index 2 is the timeout at 0x08. Index 3 is the refresh window at 0x0C. A nonzero window makes the block stricter. A refresh that lands while the count is still below the window value is treated as a fault, just like a wrong or late key word.

Three state machines make up the block.

The key checker has these states:
- `KS_IDLE`: waiting for a first key word.
- `KS_REF_HALF`: the first refresh word has been seen.
- `KS_UNL_HALF`: the first unlock word has been seen.

Its transitions are:
- `KS_IDLE` moves to `KS_REF_HALF` on 0xA602, and to `KS_UNL_HALF` on 0xC520.
- Either half state returns to `KS_IDLE` on the next key write, whether that word is correct or wrong.
- Either half state also returns to `KS_IDLE` on gap expiry.

The configuration gate has the states `CF_LOCKED` and `CF_OPEN`:
- It moves from `CF_LOCKED` to `CF_OPEN` on a permitted unlock.
- It stays in `CF_OPEN` and restarts its timer on a further permitted unlock.
- It returns to `CF_LOCKED` when the window timer ends.

The counter core has the states `WD_RUN` and `WD_TRIPPED`. It moves from `WD_RUN` to `WD_TRIPPED` on any fault, and it never leaves `WD_TRIPPED` until reset.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control register reads 0x0080: enable (bit 7) is 1, update (bit 5) is 0, and the unlocked flag (bit 11) and the applied flag (bit 10) are both 0. The timeout reads 0x0400, the window reads 0, the count starts at 0, and `rst_req` is low.
- R2: A refresh restarts the count at zero. A refresh is 0xA602 followed by 0xB480, written to index 1. The count reads 0 in the cycle after the second word.
- R3: While enabled, the count rises by one per cycle. `rst_req` is high for exactly one cycle, T+1 cycles after the count restarted from 0, where T is the timeout value.
- R4: The second word of a pair must be the next write to index 1, and it must arrive within 16 cycles of the first word. A wrong second word raises `rst_req` in the next cycle. If no second word arrives, `rst_req` rises 16 cycles after the first word.
- R5: With a nonzero window W, a refresh whose second word arrives while the count is below W raises `rst_req` instead of restarting the count. With a window of 0, no such check is made.
- R6: An unlock is 0xC520 followed by 0xD928, written to index 1. A permitted unlock sets bit 11 for the next 128 cycles, after which bit 11 clears.
- R7: Some writes take effect only while bit 11 is set. These are: enable and update bits to index 0, timeout to index 2, and window to index 3. Writes to these registers while bit 11 is clear leave them unchanged. Any applied write sets bit 10.
- R8: An unlock is permitted only while bit 10 is clear or bit 5 is set. Otherwise the unlock pair is ignored, bit 11 stays clear, and no fault is raised.
- R9: While enable is 0, the count holds its value and no timeout reset request occurs.
- R10: After a reset request the count holds its value, no further `rst_req` pulse occurs, and key words have no effect until reset.
- R11: A write to index 1 in the idle key state is ignored if it is neither 0xA602 nor 0xC520. It raises no fault and does not disturb the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_sel | input | 2 | Register index: 0 control, 1 count/key, 2 timeout, 3 window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the register chosen by `bus_sel` |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The checker watches several rules on every cycle:
- The reset request is a single-cycle pulse.
- The count and the tripped state are frozen after a trip.
- The count is frozen while the counter is disabled.
- A refresh zeroes the count when no window applies.
- The unlocked flag only rises after a permitted unlock.
- The applied flag only rises during an open window.
- A frozen configuration can never reopen.

Other behaviour can only be shown by the bench's timed scenarios:
- The exact T+1 cycle delay of the timeout, swept over several timeouts.
- The 16-cycle key gap boundary.
- The early-refresh boundary for each window value.
- The exact 128-cycle length of the unlock window.
- That writes while locked are dropped.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    // register data width and register index values
    localparam int REG_W = 16;
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_KEY  = 2'd1;
    localparam logic [1:0] SEL_TOUT = 2'd2;
    localparam logic [1:0] SEL_WIN  = 2'd3;

    // key words
    localparam logic [15:0] KEY_REF_A = 16'hA602;
    localparam logic [15:0] KEY_REF_B = 16'hB480;
    localparam logic [15:0] KEY_UNL_A = 16'hC520;
    localparam logic [15:0] KEY_UNL_B = 16'hD928;

    // control/status bit positions
    localparam int BIT_UPD  = 5;
    localparam int BIT_EN   = 7;
    localparam int BIT_DONE = 10;
    localparam int BIT_OPEN = 11;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_REF_HALF,
        KS_UNL_HALF
    } key_state_e;

    typedef enum logic {
        CF_LOCKED,
        CF_OPEN
    } cfg_state_e;

    typedef enum logic {
        WD_RUN,
        WD_TRIPPED
    } wd_state_e;

endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
    import wdk_pkg::*;
#(
    parameter int KEY_GAP = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [15:0] key_word,
    output logic        refresh_ok,
    output logic        unlock_ok,
    output logic        key_fault
);

    localparam int GAP_W = $clog2(KEY_GAP + 1);

    key_state_e         state_q, state_d;
    logic [GAP_W-1:0]   gap_q, gap_d;
    logic               gap_expired;

    assign gap_expired = (gap_q == GAP_W'(KEY_GAP - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        unique case (state_q)
            KS_IDLE: begin
                gap_d = '0;
                if (key_wr && key_word == KEY_REF_A) begin
                    state_d = KS_REF_HALF;
                end else if (key_wr && key_word == KEY_UNL_A) begin
                    state_d = KS_UNL_HALF;
                end
            end
            KS_REF_HALF, KS_UNL_HALF: begin
                gap_d = gap_q + 1'b1;
                if (key_wr || gap_expired) begin
                    state_d = KS_IDLE;
                end
            end
            default: state_d = KS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        refresh_ok = 1'b0;
        unlock_ok  = 1'b0;
        key_fault  = 1'b0;
        unique case (state_q)
            KS_IDLE: ;
            KS_REF_HALF: begin
                if (key_wr) begin
                    if (key_word == KEY_REF_B) refresh_ok = 1'b1;
                    else                       key_fault  = 1'b1;
                end else if (gap_expired) begin
                    key_fault = 1'b1;
                end
            end
            KS_UNL_HALF: begin
                if (key_wr) begin
                    if (key_word == KEY_UNL_B) unlock_ok = 1'b1;
                    else                       key_fault = 1'b1;
                end else if (gap_expired) begin
                    key_fault = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wdk_cfg.sv
module wdk_cfg
    import wdk_pkg::*;
#(
    parameter int          CNT_W    = 16,
    parameter int          OPEN_CYC = 128,
    parameter int unsigned TOUT_RST = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unlock_ok,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [REG_W-1:0] cfg_data,
    output logic             en,
    output logic             upd,
    output logic             done,
    output logic             open,
    output logic [CNT_W-1:0] timeout,
    output logic [CNT_W-1:0] window
);

    localparam int OPEN_W = $clog2(OPEN_CYC + 1);

    cfg_state_e        state_q, state_d;
    logic [OPEN_W-1:0] timer_q, timer_d;
    logic              permit;
    logic              accept;
    logic              unused_data_bits;

    assign permit           = !done || upd;
    assign unused_data_bits = ^cfg_data;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CF_LOCKED;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        unique case (state_q)
            CF_LOCKED: begin
                timer_d = '0;
                if (unlock_ok && permit) state_d = CF_OPEN;
            end
            CF_OPEN: begin
                if (unlock_ok && permit) begin
                    timer_d = '0;
                end else if (timer_q == OPEN_W'(OPEN_CYC - 1)) begin
                    state_d = CF_LOCKED;
                    timer_d = '0;
                end else begin
                    timer_d = timer_q + 1'b1;
                end
            end
            default: state_d = CF_LOCKED;
        endcase
    end

    // outputs
    assign open   = (state_q == CF_OPEN);
    assign accept = open && cfg_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en      <= 1'b1;
            upd     <= 1'b0;
            done    <= 1'b0;
            timeout <= CNT_W'(TOUT_RST);
            window  <= '0;
        end else if (accept) begin
            done <= 1'b1;
            unique case (cfg_sel)
                SEL_CTRL: begin
                    en  <= cfg_data[BIT_EN];
                    upd <= cfg_data[BIT_UPD];
                end
                SEL_TOUT: timeout <= cfg_data[CNT_W-1:0];
                SEL_WIN:  window  <= cfg_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
    import wdk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] timeout,
    input  logic [CNT_W-1:0] window,
    input  logic             refresh_ok,
    input  logic             key_fault,
    output logic [CNT_W-1:0] count,
    output logic             tripped,
    output logic             rst_req
);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             early;
    logic             expire;
    logic             fault;

    assign early  = refresh_ok && (window != '0) && (count_q < window);
    assign expire = en && (count_q == timeout);
    assign fault  = key_fault || early || expire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_RUN;
            count_q <= '0;
            rst_req <= 1'b0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            rst_req <= (state_q == WD_RUN) && fault;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            WD_RUN: begin
                if (fault)           state_d = WD_TRIPPED;
                else if (refresh_ok) count_d = '0;
                else if (en)         count_d = count_q + 1'b1;
            end
            WD_TRIPPED: ;
            default: state_d = WD_TRIPPED;
        endcase
    end

    // outputs
    assign count   = count_q;
    assign tripped = (state_q == WD_TRIPPED);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdk_pkg::*;
#(
    parameter int          CNT_W    = 16,
    parameter int          KEY_GAP  = 16,
    parameter int          OPEN_CYC = 128,
    parameter int unsigned TOUT_RST = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_sel,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             rst_req
);

    logic             key_wr;
    logic             cfg_wr;
    logic             refresh_ok;
    logic             unlock_ok;
    logic             key_fault;
    logic             tripped;
    logic             cfg_en;
    logic             cfg_upd;
    logic             cfg_done;
    logic             cfg_open;
    logic [CNT_W-1:0] cfg_tout;
    logic [CNT_W-1:0] cfg_win;
    logic [CNT_W-1:0] cnt_val;

    assign key_wr = bus_wr && (bus_sel == SEL_KEY) && !tripped;
    assign cfg_wr = bus_wr && (bus_sel != SEL_KEY);

    wdk_keyseq #(.KEY_GAP(KEY_GAP)) i_keyseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr     (key_wr),
        .key_word   (bus_wdata),
        .refresh_ok (refresh_ok),
        .unlock_ok  (unlock_ok),
        .key_fault  (key_fault)
    );

    wdk_cfg #(
        .CNT_W    (CNT_W),
        .OPEN_CYC (OPEN_CYC),
        .TOUT_RST (TOUT_RST)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .unlock_ok (unlock_ok),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (bus_sel),
        .cfg_data  (bus_wdata),
        .en        (cfg_en),
        .upd       (cfg_upd),
        .done      (cfg_done),
        .open      (cfg_open),
        .timeout   (cfg_tout),
        .window    (cfg_win)
    );

    wdk_counter #(.CNT_W(CNT_W)) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_en),
        .timeout    (cfg_tout),
        .window     (cfg_win),
        .refresh_ok (refresh_ok),
        .key_fault  (key_fault),
        .count      (cnt_val),
        .tripped    (tripped),
        .rst_req    (rst_req)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_sel)
            SEL_CTRL: begin
                bus_rdata[BIT_EN]   = cfg_en;
                bus_rdata[BIT_UPD]  = cfg_upd;
                bus_rdata[BIT_DONE] = cfg_done;
                bus_rdata[BIT_OPEN] = cfg_open;
            end
            SEL_KEY:  bus_rdata = REG_W'(cnt_val);
            SEL_TOUT: bus_rdata = REG_W'(cfg_tout);
            SEL_WIN:  bus_rdata = REG_W'(cfg_win);
            default: ;
        endcase
    end

endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic             refresh_ok,
    input logic             unlock_ok,
    input logic             tripped,
    input logic             en,
    input logic             upd,
    input logic             done,
    input logic             open,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] window
);

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_ok && !tripped && window == '0) |=> (count == '0 || tripped));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_unlock_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(unlock_ok));

    assert_applied_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(open));

    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !upd && !open) |=> !open);

    assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !refresh_ok) |=> $stable(count));

    assert_trip_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tripped |=> ($stable(count) && tripped && !rst_req));

endmodule

bind keyed_watchdog wdk_checker #(.CNT_W(CNT_W)) i_wdk_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_req    (rst_req),
    .refresh_ok (refresh_ok),
    .unlock_ok  (unlock_ok),
    .tripped    (tripped),
    .en         (cfg_en),
    .upd        (cfg_upd),
    .done       (cfg_done),
    .open       (cfg_open),
    .count      (cnt_val),
    .window     (cfg_win)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] S_CTRL = 2'd0, S_KEY = 2'd1, S_TOUT = 2'd2, S_WIN = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        rst_req;

    int n_checks = 0;
    int n_fail = 0;
    int pulse_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        #2;
        if (rst_req) pulse_cnt++;
    end

    keyed_watchdog i_keyed_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_wr = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        bus_wr = 1'b1;
        bus_sel = s;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output int v);
        bus_sel = s;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic refresh();
        wr(S_KEY, 16'hA602);
        wr(S_KEY, 16'hB480);
    endtask

    task automatic unlock();
        wr(S_KEY, 16'hC520);
        wr(S_KEY, 16'hD928);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        int p0;
        int tvals[6] = '{1, 2, 3, 5, 8, 13};
        int wvals[3] = '{0, 3, 5};
        int gvals[5] = '{0, 8, 15, 16, 17};

        @(negedge clk);

        // R1 reset state
        do_reset();
        rd(S_CTRL, v); chk("R1 ctrl", v, 'h0080);
        rd(S_TOUT, v); chk("R1 timeout", v, 'h0400);
        rd(S_WIN, v);  chk("R1 window", v, 0);
        rd(S_KEY, v);  chk("R1 count", v, 0);
        chk("R1 rst_req", int'(rst_req), 0);

        // R3 timeout sweep, then R10 hold
        for (int i = 0; i < 6; i++) begin
            do_reset();
            unlock();
            wr(S_CTRL, 16'h0020);
            wr(S_TOUT, 16'(tvals[i]));
            refresh();
            wr(S_CTRL, 16'h00A0);
            for (int n = 1; n <= tvals[i] + 2; n++) begin
                idle(1);
                chk("R3 pulse timing", int'(rst_req), int'(n == tvals[i] + 1));
            end
            p0 = pulse_cnt;
            rd(S_KEY, v); chk("R10 count frozen", v, tvals[i]);
            idle(10);
            refresh();
            idle(3);
            rd(S_KEY, v); chk("R10 keys ignored", v, tvals[i]);
            chk("R10 no further pulse", pulse_cnt - p0, 0);
        end

        // R9 disabled counter
        do_reset();
        unlock();
        wr(S_CTRL, 16'h0020);
        wr(S_TOUT, 16'd3);
        refresh();
        p0 = pulse_cnt;
        idle(30);
        rd(S_KEY, v); chk("R9 count held", v, 0);
        chk("R9 no timeout reset", pulse_cnt - p0, 0);

        // R5 window sweep
        for (int i = 0; i < 3; i++) begin
            for (int d = 0; d <= 6; d++) begin
                do_reset();
                unlock();
                wr(S_WIN, 16'(wvals[i]));
                idle(20);
                refresh();
                idle(d);
                refresh();
                chk("R5 early refresh", int'(rst_req), int'((wvals[i] != 0) && (d + 1 < wvals[i])));
                if (!((wvals[i] != 0) && (d + 1 < wvals[i]))) begin
                    rd(S_KEY, v); chk("R2 refresh restart", v, 0);
                end
            end
        end

        // R4 key gap sweep
        for (int i = 0; i < 5; i++) begin
            do_reset();
            p0 = pulse_cnt;
            wr(S_KEY, 16'hA602);
            idle(gvals[i]);
            chk("R4 gap fault", int'(pulse_cnt - p0 > 0), int'(gvals[i] >= 16));
            wr(S_KEY, 16'hB480);
            if (gvals[i] < 16) begin
                rd(S_KEY, v); chk("R4 in-time refresh", v, 0);
            end
        end

        // R4 wrong second words
        do_reset();
        wr(S_KEY, 16'hA602);
        wr(S_KEY, 16'h1234);
        chk("R4 wrong refresh word", int'(rst_req), 1);
        do_reset();
        wr(S_KEY, 16'hC520);
        wr(S_KEY, 16'hA602);
        chk("R4 wrong unlock word", int'(rst_req), 1);

        // R11 stray key words
        do_reset();
        p0 = pulse_cnt;
        idle(5);
        wr(S_KEY, 16'h1111);
        wr(S_KEY, 16'hB480);
        idle(3);
        rd(S_KEY, v); chk("R11 count undisturbed", v, 10);
        chk("R11 no fault", pulse_cnt - p0, 0);

        // R7 locked writes dropped, open writes applied
        do_reset();
        wr(S_TOUT, 16'h0077);
        wr(S_WIN, 16'h0009);
        wr(S_CTRL, 16'h0000);
        rd(S_TOUT, v); chk("R7 locked timeout", v, 'h0400);
        rd(S_WIN, v);  chk("R7 locked window", v, 0);
        rd(S_CTRL, v); chk("R7 locked ctrl", v, 'h0080);
        unlock();
        wr(S_TOUT, 16'h0300);
        rd(S_TOUT, v); chk("R7 open timeout", v, 'h0300);
        rd(S_CTRL, v); chk("R7 applied flag", v, 'h0C80);

        // R6 window length, R8 permission
        do_reset();
        unlock();
        rd(S_CTRL, v); chk("R6 unlocked set", (v >> 11) & 1, 1);
        idle(127);
        rd(S_CTRL, v); chk("R6 last open cycle", (v >> 11) & 1, 1);
        idle(1);
        rd(S_CTRL, v); chk("R6 window closed", (v >> 11) & 1, 0);
        wr(S_TOUT, 16'h0055);
        rd(S_TOUT, v); chk("R7 write after close", v, 'h0400);
        unlock();
        rd(S_CTRL, v); chk("R8 unlock while unapplied", (v >> 11) & 1, 1);
        wr(S_CTRL, 16'h0080);
        idle(128);
        rd(S_CTRL, v); chk("R8 closed before retry", (v >> 11) & 1, 0);
        p0 = pulse_cnt;
        unlock();
        rd(S_CTRL, v); chk("R8 frozen unlock refused", (v >> 11) & 1, 0);
        chk("R8 refused unlock no fault", pulse_cnt - p0, 0);

        do_reset();
        unlock();
        wr(S_CTRL, 16'h00A0);
        idle(128);
        unlock();
        rd(S_CTRL, v); chk("R8 update allows unlock", (v >> 11) & 1, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule